// File: doc/BRIEF.md
# Selectable-Source Scanline Interrupt Timer

This block is a programmable interrupt timer for a cartridge memory controller. It has an 8-bit event counter that is fed by a prescaler. The counter can count up or down. The counter is clocked by one of four event streams:
- a CPU cycle strobe,
- a glitch-filtered rising edge on video address line A12,
- any change of the video address,
- a CPU-write source that steps on every CPU cycle.

When the counter wraps past its end value while interrupts are enabled, a pending flag is set. The flag drives a level interrupt output, and it stays set until software acknowledges it.

Software controls the block through a small write-only register port. The port has these registers:
- a control register,
- a mode register,
- an acknowledge address,
- an enable address,
- two load registers, for the prescaler and for the counter,
- a key register.

A value written to either load register is XORed with the key before it is stored. In narrow mode only the low three bits of the prescaler run, so the counter steps once every eight events instead of once every 256.

Top module: `irq_tick_timer`

## Requirements
- R1: After reset `irq_o` is 0. The direction is frozen, the source is the CPU cycle, and the prescaler, counter, key and enable are all zero. Events do not count until a mode is written.
- R2: Mode register (`wr_sel`=1) bits 7:6 set the direction: 1 counts up, 2 counts down, and 0 or 3 freezes the prescaler and the counter with their values kept.
- R3: Mode bits 1:0 select the event: 0 = `cpu_tick`, 1 = filtered A12 rise, 2 = `vid_addr_chg`, 3 = `cpu_tick` (CPU-write source). An event that is not selected has no effect.
- R4: Mode bit 2 set makes only prescaler bits 2:0 active. Bits 7:3 keep their value and count again once the bit is cleared.
- R5: Counting up, the active prescaler bits increment, and the counter steps once when they wrap to zero. A counter step from 0xFF to 0x00 sets pending.
- R6: Counting down, the active prescaler bits decrement, and the counter steps when they reach zero. A prescaler at 0 reloads to all ones without a step. A counter step from 0x00 to 0xFF sets pending.
- R7: A wrap sets pending only if the interrupt was enabled before that cycle. Enabling later does not raise a pending flag for an earlier wrap.
- R8: Writes to prescaler load (`wr_sel`=4) and counter load (`wr_sel`=5) store `wr_data` XOR key. The key is written at `wr_sel`=6.
- R9: Control (`wr_sel`=0) with bit 0 = 1 enables the interrupt; with bit 0 = 0 it disables it and clears pending. `wr_sel`=2 disables and clears pending. `wr_sel`=3 only enables.
- R10: An A12 rising edge counts only if A12 was sampled low during at least 3 `cpu_tick` cycles since it was last high.
- R11: `irq_o` is the registered pending flag. It stays 1 until it is cleared as in R9. Reloading the counter or the prescaler does not clear it.
- R12: In a cycle where a counter load and a counter step coincide, the load wins and no pending flag is set. In a cycle where a clear and a set coincide, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One-cycle strobe per CPU cycle |
| vid_a12 | input | 1 | Level of video address line A12 |
| vid_addr_chg | input | 1 | One-cycle strobe on each video address change |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 control, 1 mode, 2 acknowledge, 3 enable, 4 prescaler load, 5 counter load, 6 key) |
| wr_data | input | DATA_W | Write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is a prescaler whose upper bits hold a value left over from narrow mode. The bench loads 0xF6 in narrow mode and counts until the low bits wrap, which leaves 0xF0 in the register. It then switches to full-width counting and checks that the interrupt arrives after exactly 16 events, not 256. The A12 filter is reached by holding the line high while the registers are set up, so that the stored low time starts at zero. A low phase of two CPU cycles must then be rejected and a low phase of three accepted. Coincident load/step and clear/set cycles are driven in the same clock to check the priority rules.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

   localparam int unsigned SEL_W = 3;

   typedef enum logic [1:0] {
      DIR_HOLD_LO = 2'd0,
      DIR_UP      = 2'd1,
      DIR_DOWN    = 2'd2,
      DIR_HOLD_HI = 2'd3
   } irqt_dir_e;

   typedef enum logic [1:0] {
      SRC_CPU   = 2'd0,
      SRC_A12   = 2'd1,
      SRC_VADDR = 2'd2,
      SRC_CPUWR = 2'd3
   } irqt_src_e;

   typedef enum logic [SEL_W-1:0] {
      REG_CTRL = 3'd0,
      REG_MODE = 3'd1,
      REG_ACK  = 3'd2,
      REG_ARM  = 3'd3,
      REG_PRE  = 3'd4,
      REG_CNT  = 3'd5,
      REG_KEY  = 3'd6,
      REG_NONE = 3'd7
   } irqt_reg_e;

   // bit positions inside the mode byte
   localparam int unsigned MODE_DIR_LSB = 6;
   localparam int unsigned MODE_NARROW  = 2;
   localparam int unsigned MODE_SRC_LSB = 0;

endpackage

// File: rtl/irqt_a12_filter.sv
module irqt_a12_filter #(
   parameter int unsigned LOW_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_tick,
   input  logic a12,
   output logic rise_o
);
   localparam int unsigned CW = (LOW_MIN < 1) ? 1 : $clog2(LOW_MIN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LOW_MIN);

   logic [CW-1:0] low_q;
   logic          a12_q;

   // edge is accepted only after enough low CPU cycles
   assign rise_o = a12 & ~a12_q & (low_q >= LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         a12_q <= 1'b0;
      end else begin
         a12_q <= a12;
         if (a12) begin
            low_q <= '0;
         end else if (cpu_tick && (low_q < LIMIT)) begin
            low_q <= low_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
   parameter int unsigned W        = 8,
   parameter int unsigned NARROW_W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         count_up,
   input  logic         count_dn,
   input  logic         narrow,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         carry_o,
   output logic [W-1:0] pre_o
);
   localparam logic [W-1:0] NMASK = {{(W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [W-1:0] pre_q, mask, masked, inc, dec, nxt;
   logic         carry;

   assign mask   = narrow ? NMASK : {W{1'b1}};
   assign masked = pre_q & mask;
   assign inc    = masked + 1'b1;
   assign dec    = masked - 1'b1;

   always_comb begin
      nxt   = pre_q;
      carry = 1'b0;
      if (step && count_up) begin
         nxt   = (pre_q & ~mask) | (inc & mask);
         carry = ((inc & mask) == '0);
      end else if (step && count_dn) begin
         nxt   = (pre_q & ~mask) | (dec & mask);
         carry = (dec == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (load) begin
         pre_q <= load_val;
      end else begin
         pre_q <= nxt;
      end
   end

   assign carry_o = carry;
   assign pre_o   = pre_q;
endmodule

// File: rtl/irqt_counter.sv
module irqt_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         count_up,
   input  logic         count_dn,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         wrap_o,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   // a load in the same cycle discards the step and its wrap
   assign wrap_o = step & ~load &
                   ((count_up & (cnt_q == TOP)) | (count_dn & (cnt_q == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (step && count_up) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (step && count_dn) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
   import irqt_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NARROW_W    = 3,
   parameter int unsigned A12_LOW_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_tick,
   input  logic              vid_a12,
   input  logic              vid_addr_chg,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq_o
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("irq_tick_timer: DATA_W must be at least 8");
      end
      if ((NARROW_W < 1) || (NARROW_W >= DATA_W)) begin : g_bad_narrow
         $error("irq_tick_timer: NARROW_W must be in 1..DATA_W-1");
      end
   endgenerate

   irqt_dir_e         dir_q;
   irqt_src_e         src_q;
   logic              narrow_q;
   logic              en_q;
   logic              pend_q;
   logic [DATA_W-1:0] key_q;

   logic wr_ctrl, wr_mode, wr_ack, wr_arm, wr_pre, wr_cnt, wr_key;
   assign wr_ctrl = wr_en && (wr_sel == REG_CTRL);
   assign wr_mode = wr_en && (wr_sel == REG_MODE);
   assign wr_ack  = wr_en && (wr_sel == REG_ACK);
   assign wr_arm  = wr_en && (wr_sel == REG_ARM);
   assign wr_pre  = wr_en && (wr_sel == REG_PRE);
   assign wr_cnt  = wr_en && (wr_sel == REG_CNT);
   assign wr_key  = wr_en && (wr_sel == REG_KEY);

   logic [DATA_W-1:0] keyed_val;
   assign keyed_val = wr_data ^ key_q;

   // A12 edge source: filtered or raw, chosen by parameter
   logic a12_rise;
   generate
      if (A12_LOW_MIN == 0) begin : g_a12_raw
         logic a12_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) a12_q <= 1'b0;
            else        a12_q <= vid_a12;
         end
         assign a12_rise = vid_a12 & ~a12_q;
      end else begin : g_a12_filt
         irqt_a12_filter #(.LOW_MIN(A12_LOW_MIN)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .cpu_tick (cpu_tick),
            .a12      (vid_a12),
            .rise_o   (a12_rise)
         );
      end
   endgenerate

   logic src_step;
   always_comb begin
      case (src_q)
         SRC_CPU, SRC_CPUWR: src_step = cpu_tick;
         SRC_A12:            src_step = a12_rise;
         SRC_VADDR:          src_step = vid_addr_chg;
         default:            src_step = 1'b0;
      endcase
   end

   logic count_up, count_dn;
   assign count_up = (dir_q == DIR_UP);
   assign count_dn = (dir_q == DIR_DOWN);

   logic              pre_carry, cnt_wrap;
   logic [DATA_W-1:0] pre_w, cnt_w;

   irqt_prescaler #(.W(DATA_W), .NARROW_W(NARROW_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (src_step),
      .count_up (count_up),
      .count_dn (count_dn),
      .narrow   (narrow_q),
      .load     (wr_pre),
      .load_val (keyed_val),
      .carry_o  (pre_carry),
      .pre_o    (pre_w)
   );

   irqt_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (pre_carry),
      .count_up (count_up),
      .count_dn (count_dn),
      .load     (wr_cnt),
      .load_val (keyed_val),
      .wrap_o   (cnt_wrap),
      .cnt_o    (cnt_w)
   );

   logic pend_clr;
   assign pend_clr = wr_ack | (wr_ctrl & ~wr_data[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= DIR_HOLD_LO;
         src_q    <= SRC_CPU;
         narrow_q <= 1'b0;
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
         key_q    <= '0;
      end else begin
         if (wr_mode) begin
            dir_q    <= irqt_dir_e'(wr_data[MODE_DIR_LSB +: 2]);
            src_q    <= irqt_src_e'(wr_data[MODE_SRC_LSB +: 2]);
            narrow_q <= wr_data[MODE_NARROW];
         end
         if (wr_key) key_q <= wr_data;
         if (wr_ctrl)     en_q <= wr_data[0];
         else if (wr_ack) en_q <= 1'b0;
         else if (wr_arm) en_q <= 1'b1;
         if (pend_clr)                pend_q <= 1'b0;
         else if (cnt_wrap && en_q)   pend_q <= 1'b1;
      end
   end

   assign irq_o = pend_q;
endmodule

// File: rtl/irqt_checker.sv
module irqt_checker
   import irqt_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NARROW_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [SEL_W-1:0]  wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              irq_o,
   input logic              en_q,
   input logic [1:0]        dir_q,
   input logic              narrow_q,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] pre_q
);
   logic clr_wr;
   assign clr_wr = wr_en && ((wr_sel == REG_ACK) || ((wr_sel == REG_CTRL) && !wr_data[0]));

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_wr) |=> irq_o); // R11

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (!irq_o && !en_q)); // R9

   AST_CTRL_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == REG_CTRL) && wr_data[0]) |=> en_q); // R9

   AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(en_q)); // R7

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (((dir_q == 2'd0) || (dir_q == 2'd3)) && !(wr_en && (wr_sel == REG_CNT)))
      |=> $stable(cnt_q)); // R2

   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow_q && !(wr_en && (wr_sel == REG_PRE)))
      |=> $stable(pre_q[DATA_W-1:NARROW_W])); // R4
endmodule

bind irq_tick_timer irqt_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .irq_o    (irq_o),
   .en_q     (en_q),
   .dir_q    (dir_q),
   .narrow_q (narrow_q),
   .cnt_q    (cnt_w),
   .pre_q    (pre_w)
);

// File: tb/irq_tick_timer_tb_top.sv
`timescale 1ns/1ps
module irq_tick_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_tick = 1'b0;
   logic       vid_a12 = 1'b0;
   logic       vid_addr_chg = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic       irq_o;

   always #2.5 clk = ~clk;

   irq_tick_timer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_tick     (cpu_tick),
      .vid_a12      (vid_a12),
      .vid_addr_chg (vid_addr_chg),
      .wr_en        (wr_en),
      .wr_sel       (wr_sel),
      .wr_data      (wr_data),
      .irq_o        (irq_o)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   bit    reported = 0;
   string phase = "R1";

   // behavioural reference state
   int m_pre, m_cnt, m_key, m_dir, m_src, m_low;
   bit m_en, m_pend, m_narrow, m_a12p;
   int msk, p, nc;
   bit rise, stp, cstep, setp, clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_key = 0; m_dir = 0; m_src = 0; m_low = 0;
         m_en = 0; m_pend = 0; m_narrow = 0; m_a12p = 0;
      end else begin
         rise = vid_a12 && !m_a12p && (m_low >= 3);
         if (vid_a12) m_low = 0;
         else if (cpu_tick && m_low < 3) m_low = m_low + 1;
         m_a12p = vid_a12;
         if (m_src == 1)      stp = rise;
         else if (m_src == 2) stp = vid_addr_chg;
         else                 stp = cpu_tick;
         cstep = 0; setp = 0; clr = 0;
         if (stp && (m_dir == 1 || m_dir == 2)) begin
            msk = m_narrow ? 7 : 255;
            p = m_pre & msk;
            if (m_dir == 1) begin p = (p + 1) & msk; cstep = (p == 0); end
            else begin p = p - 1; cstep = (p == 0); p = p & msk; end
            m_pre = (m_pre & (255 - msk)) | p;
         end
         if (cstep) begin
            if (m_dir == 1) begin nc = (m_cnt + 1) & 255; setp = (nc == 0); end
            else begin nc = (m_cnt + 255) & 255; setp = (nc == 255); end
            m_cnt = nc;
         end
         setp = setp && m_en;
         if (wr_en) begin
            case (wr_sel)
               3'd0: if (wr_data[0]) m_en = 1; else begin m_en = 0; clr = 1; end
               3'd1: begin m_dir = wr_data[7:6]; m_narrow = wr_data[2]; m_src = wr_data[1:0]; end
               3'd2: begin m_en = 0; clr = 1; end
               3'd3: m_en = 1;
               3'd4: m_pre = wr_data ^ m_key[7:0];
               3'd5: begin m_cnt = wr_data ^ m_key[7:0]; setp = 0; end
               3'd6: m_key = wr_data;
               default: ;
            endcase
         end
         m_pend = clr ? 1'b0 : (m_pend | setp);
      end
   end

   // clock-by-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_o !== m_pend) begin
            errors++;
            $display("FAIL %s model compare: irq_o actual %0b expected %0b", phase, irq_o, m_pend);
         end
      end
   end

   task automatic chk(input bit exp, input string tag);
      checks++;
      if (irq_o !== exp) begin
         errors++;
         $display("FAIL %s: irq_o actual %0b expected %0b", tag, irq_o, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); cpu_tick = 1'b1; end
      @(negedge clk); cpu_tick = 1'b0;
   endtask

   task automatic vchg(input int n);
      for (int i = 0; i < n; i++) begin @(negedge clk); vid_addr_chg = 1'b1; end
      @(negedge clk); vid_addr_chg = 1'b0;
   endtask

   task automatic rearm();
      wr(3'd2, 8'h00); wr(3'd3, 8'h00);
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!reported) begin
         done = 1; errors++; checks++;
         $display("FAIL watchdog: run actual hung expected finish");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      phase = "R1"; chk(0, "R1 reset irq");
      ticks(5); chk(0, "R1 frozen after reset");
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd1, 8'h40); wr(3'd3, 8'h00);
      chk(0, "R1 before tick");
      ticks(1); chk(1, "R1 key zero after reset / R5 wrap");

      phase = "R9";
      wr(3'd0, 8'h00); chk(0, "R9 control bit0 clear acks");
      wr(3'd0, 8'h01); chk(0, "R9 control enable alone");

      phase = "R8";
      wr(3'd6, 8'h5A); wr(3'd5, 8'hA5); wr(3'd4, 8'hA4);
      ticks(1); chk(0, "R8 keyed prescaler FE->FF");
      ticks(1); chk(1, "R8 keyed counter FF wraps");

      phase = "R11";
      wr(3'd5, 8'h33); chk(1, "R11 counter reload keeps irq");
      wr(3'd4, 8'h00); ticks(3); chk(1, "R11 stays asserted");
      wr(3'd2, 8'h00); chk(0, "R9 acknowledge address clears");

      phase = "R7";
      wr(3'd6, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      ticks(1); chk(0, "R7 wrap while disabled");
      wr(3'd3, 8'h00); chk(0, "R7 later enable no retro pending");

      phase = "R5";
      wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
      ticks(255); chk(0, "R5 255 events no step");
      ticks(1); chk(1, "R5 256th event wraps counter");

      phase = "R6";
      rearm(); wr(3'd1, 8'h80); wr(3'd4, 8'h02); wr(3'd5, 8'h00);
      ticks(1); chk(0, "R6 prescaler 2->1");
      ticks(1); chk(1, "R6 prescaler hits 0, counter to FF");
      rearm(); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
      ticks(255); chk(0, "R6 prescaler 0 reloads without step");
      ticks(1); chk(1, "R6 step after full down run");

      phase = "R4";
      rearm(); wr(3'd1, 8'h44); wr(3'd4, 8'hF6); wr(3'd5, 8'hFF);
      ticks(1); chk(0, "R4 narrow low bits 6->7");
      ticks(1); chk(1, "R4 narrow wrap after 2 events");
      rearm(); wr(3'd5, 8'hFF); wr(3'd1, 8'h40);
      ticks(15); chk(0, "R4 upper bits kept, 15 events");
      ticks(1); chk(1, "R4 upper bits kept, 16th event wraps");

      phase = "R2";
      rearm(); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd1, 8'h00);
      ticks(10); chk(0, "R2 direction 0 frozen");
      wr(3'd1, 8'hC0); ticks(10); chk(0, "R2 direction 3 frozen");
      wr(3'd1, 8'h40); ticks(1); chk(1, "R2 state kept while frozen");

      phase = "R3";
      rearm(); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd1, 8'h42);
      ticks(5); chk(0, "R3 cpu tick ignored on source 2");
      vchg(1); chk(1, "R3 address change counts on source 2");
      rearm(); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd1, 8'h43);
      vchg(4); chk(0, "R3 address change ignored on source 3");
      ticks(1); chk(1, "R3 source 3 steps on cpu cycle");
      rearm(); wr(3'd1, 8'h40); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      vchg(3); chk(0, "R3 address change ignored on source 0");
      ticks(1); chk(1, "R3 source 0 steps on cpu cycle");

      phase = "R10";
      rearm();
      @(negedge clk); vid_a12 = 1'b1;
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd1, 8'h41);
      @(negedge clk); vid_a12 = 1'b0;
      ticks(2);
      @(negedge clk); vid_a12 = 1'b1;
      @(negedge clk);
      chk(0, "R10 short low phase rejected");
      vid_a12 = 1'b0;
      ticks(3);
      @(negedge clk); vid_a12 = 1'b1;
      @(negedge clk);
      chk(1, "R10 three low cycles accepted");
      vid_a12 = 1'b0;

      phase = "R12";
      rearm(); wr(3'd1, 8'h40); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      @(negedge clk); cpu_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h10;
      @(negedge clk); cpu_tick = 1'b0; wr_en = 1'b0;
      chk(0, "R12 load beats counter step");
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      @(negedge clk); cpu_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h00;
      @(negedge clk); cpu_tick = 1'b0; wr_en = 1'b0;
      chk(0, "R12 clear beats set");
      wr(3'd3, 8'h00); chk(0, "R12 no pending left after clear");

      done = 1;
      report();
   end
endmodule